// File: doc/BRIEF.md
# Delayed Pre-Trigger Channel

This block is one channel of a conversion-scheduling unit. It drives a group of pre-trigger strobes toward a single downstream converter. Each strobe is produced on one of two paths. The bypass path fires on the clock after the trigger strobe. The delayed path fires on the clock after a shared, externally supplied counter equals that strobe's own delay value. A trigger strobe opens a counter run, and each pre-trigger fires at most once per run.

The converter accepts only one conversion at a time. When a pre-trigger fires while the converter reports busy, the channel records a sequence error for that pre-trigger. When several pre-triggers fire in the same cycle and the converter is idle, the lowest-numbered one is taken and every other one is counted as a collision.

Each pre-trigger also has a sticky fired flag. Fired flags and error flags are cleared per bit by write-one pulses from the register interface.

Top module: `pt_channel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `preTrig`, `fireFlags` and `errFlags` are all zero.
- R2: When pre-trigger m is enabled and its select bit is 0 (bypass), a `trigStrobe` sampled in cycle t makes `preTrig[m]` high in cycle t+1.
- R3: When pre-trigger m is enabled and its select bit is 1 (delayed), `preTrig[m]` goes high in the cycle that follows the first cycle after the trigger cycle in which `cntVal` equals `ptDelay[m*16 +: 16]`.
- R4: A delayed pre-trigger fires at most once between two trigger strobes. Later matches of the counter in the same run are ignored, and no match is taken in the trigger cycle itself.
- R5: A pre-trigger whose enable bit is 0 in the cycle before the strobe would appear never asserts on either path.
- R6: `fireFlags[m]` is set in the cycle after `preTrig[m]` is high and stays set until it is cleared.
- R7: When `preTrig[m]` is high in a cycle in which `convBusy` is high, `errFlags[m]` is set in the next cycle and stays set until it is cleared.
- R8: When more than one pre-trigger strobes in the same cycle and `convBusy` is low, the lowest-numbered one raises no error and every higher-numbered one sets its error bit.
- R9: A 1 in bit m of `flagClear` or `errClear` clears only that bit in the next cycle. When a set and a clear of the same bit happen in the same cycle, the bit stays set.
- R10: Every pre-trigger strobe is exactly one cycle wide when `trigStrobe` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigStrobe | input | 1 | Single-cycle pulse for a detected trigger edge or a software trigger; starts a run |
| cntVal | input | 16 | Shared counter value |
| ptDelay | input | 128 | Delay values, 16 bits per pre-trigger; pre-trigger m occupies bits m*16 +: 16 |
| ptEnable | input | 8 | Per-pre-trigger enable |
| ptSelect | input | 8 | Per-pre-trigger path select: 0 = bypass, 1 = delayed |
| convBusy | input | 1 | High while the converter is converting |
| flagClear | input | 8 | Write-one pulses that clear fired flags |
| errClear | input | 8 | Write-one pulses that clear error flags |
| preTrig | output | 8 | Pre-trigger strobes |
| fireFlags | output | 8 | Sticky fired flags |
| errFlags | output | 8 | Sticky sequence-error flags |

## Verification
The bound checker watches several behaviours on every clock:
- no strobe appears from a disabled pre-trigger;
- strobes are never two cycles wide unless a new trigger arrived;
- the bypass path answers a trigger on the following cycle;
- every strobe leaves its fired flag set, and also its error flag when the converter was busy or a lower pre-trigger won the same cycle;
- a flag never drops without a clear request.

The exact cycle at which a delayed pre-trigger fires, the suppression of repeated counter matches within a run, and the set-over-clear priority are shown only by the bench. The bench sweeps enable, select, delay, counter wrap and busy-window patterns and predicts every output cycle by cycle.

// File: rtl/pt_chan_pkg.sv
package pt_chan_pkg;
  parameter int PT_NUM = 8;
  parameter int DLY_W  = 16;

  typedef struct packed {
    logic [PT_NUM-1:0] fire;
    logic [PT_NUM-1:0] collide;
  } ptStrobe_t;
endpackage

// File: rtl/pt_match_dp.sv
module pt_match_dp #(
  parameter int NUM = 8,
  parameter int W   = 16
) (
  input  logic [W-1:0]     cntVal,
  input  logic [NUM*W-1:0] ptDelay,
  output logic [NUM-1:0]   hitVec
);
  // One equality comparator per pre-trigger.
  for (genvar m = 0; m < NUM; m++) begin : g_cmp
    assign hitVec[m] = (cntVal == ptDelay[m*W +: W]);
  end
endmodule

// File: rtl/pt_seq_ctrl.sv
module pt_seq_ctrl
  import pt_chan_pkg::*;
#(
  parameter int NUM = PT_NUM
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           trigStrobe,
  input  logic [NUM-1:0] ptEnable,
  input  logic [NUM-1:0] ptSelect,
  input  logic [NUM-1:0] hitVec,
  input  logic           convBusy,
  output logic [NUM-1:0] preTrig,
  output ptStrobe_t      strobes
);
  logic [NUM-1:0] armed;
  logic [NUM-1:0] fireNext;
  logic [NUM-1:0] lowerAny;

  // In the trigger cycle only bypass pre-triggers fire; in other cycles
  // only armed delayed pre-triggers whose delay matches the counter.
  always_comb begin
    if (trigStrobe) fireNext = ptEnable & ~ptSelect;
    else            fireNext = ptEnable & ptSelect & armed & hitVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= '0;
      preTrig <= '0;
    end else begin
      preTrig <= fireNext;
      if (trigStrobe) armed <= '1;
      else            armed <= armed & ~fireNext;
    end
  end

  // Fixed priority: a strobe collides with any lower-numbered strobe.
  assign lowerAny[0] = 1'b0;
  for (genvar m = 1; m < NUM; m++) begin : g_prio
    assign lowerAny[m] = lowerAny[m-1] | preTrig[m-1];
  end

  assign strobes.fire    = preTrig;
  assign strobes.collide = preTrig & ({NUM{convBusy}} | lowerAny);
endmodule

// File: rtl/pt_flag_dp.sv
module pt_flag_dp
  import pt_chan_pkg::*;
#(
  parameter int NUM = PT_NUM
) (
  input  logic           clk,
  input  logic           rstN,
  input  ptStrobe_t      strobes,
  input  logic [NUM-1:0] flagClear,
  input  logic [NUM-1:0] errClear,
  output logic [NUM-1:0] fireFlags,
  output logic [NUM-1:0] errFlags
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fireFlags <= '0;
      errFlags  <= '0;
    end else begin
      // A set in the same cycle overrides the clear.
      fireFlags <= (fireFlags & ~flagClear) | strobes.fire;
      errFlags  <= (errFlags & ~errClear) | strobes.collide;
    end
  end
endmodule

// File: rtl/pt_channel.sv
module pt_channel
  import pt_chan_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    trigStrobe,
  input  logic [DLY_W-1:0]        cntVal,
  input  logic [PT_NUM*DLY_W-1:0] ptDelay,
  input  logic [PT_NUM-1:0]       ptEnable,
  input  logic [PT_NUM-1:0]       ptSelect,
  input  logic                    convBusy,
  input  logic [PT_NUM-1:0]       flagClear,
  input  logic [PT_NUM-1:0]       errClear,
  output logic [PT_NUM-1:0]       preTrig,
  output logic [PT_NUM-1:0]       fireFlags,
  output logic [PT_NUM-1:0]       errFlags
);
  localparam int NUM = PT_NUM;
  localparam int W   = DLY_W;

  logic [NUM-1:0] hitVec;
  ptStrobe_t      strobes;

  pt_match_dp #(.NUM(NUM), .W(W)) match_i (
    .cntVal (cntVal),
    .ptDelay(ptDelay),
    .hitVec (hitVec)
  );

  pt_seq_ctrl #(.NUM(NUM)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .trigStrobe(trigStrobe),
    .ptEnable  (ptEnable),
    .ptSelect  (ptSelect),
    .hitVec    (hitVec),
    .convBusy  (convBusy),
    .preTrig   (preTrig),
    .strobes   (strobes)
  );

  pt_flag_dp #(.NUM(NUM)) flag_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .flagClear(flagClear),
    .errClear (errClear),
    .fireFlags(fireFlags),
    .errFlags (errFlags)
  );
endmodule

// File: rtl/pt_channel_chk.sv
module pt_channel_chk #(
  parameter int NUM = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           trigStrobe,
  input logic [NUM-1:0] ptEnable,
  input logic [NUM-1:0] ptSelect,
  input logic           convBusy,
  input logic [NUM-1:0] flagClear,
  input logic [NUM-1:0] errClear,
  input logic [NUM-1:0] preTrig,
  input logic [NUM-1:0] fireFlags,
  input logic [NUM-1:0] errFlags
);
  localparam logic [NUM-1:0] ONE = NUM'(1);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((preTrig & ~$past(ptEnable)) == '0));

  a_r10_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    !$past(trigStrobe) |-> ((preTrig & $past(preTrig)) == '0));

  a_r2_bypass_next: assert property (@(posedge clk) disable iff (!rstN)
    trigStrobe |=> ((preTrig & $past(ptEnable & ~ptSelect)) == $past(ptEnable & ~ptSelect)));

  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    (preTrig != '0) |=> ((fireFlags & $past(preTrig)) == $past(preTrig)));

  a_r7_busy_error: assert property (@(posedge clk) disable iff (!rstN)
    ((preTrig != '0) && convBusy) |=> ((errFlags & $past(preTrig)) == $past(preTrig)));

  a_r8_loser_error: assert property (@(posedge clk) disable iff (!rstN)
    ((errFlags & $past(preTrig & (preTrig - ONE))) == $past(preTrig & (preTrig - ONE))));

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((~fireFlags & $past(fireFlags) & ~$past(flagClear)) == '0));

  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((~errFlags & $past(errFlags) & ~$past(errClear)) == '0));
endmodule

bind pt_channel pt_channel_chk #(.NUM(pt_chan_pkg::PT_NUM)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .trigStrobe(trigStrobe),
  .ptEnable  (ptEnable),
  .ptSelect  (ptSelect),
  .convBusy  (convBusy),
  .flagClear (flagClear),
  .errClear  (errClear),
  .preTrig   (preTrig),
  .fireFlags (fireFlags),
  .errFlags  (errFlags)
);

// File: tb/pt_channel_tb_top.sv
`timescale 1ns/1ps
module pt_channel_tb_top;
  import pt_chan_pkg::*;
  localparam int N      = PT_NUM;
  localparam int W      = DLY_W;
  localparam int RUNLEN = 30;

  logic                clk = 1'b0;
  logic                rstN;
  logic                trigStrobe;
  logic [W-1:0]        cntVal;
  logic [N-1:0][W-1:0] dly;
  logic [N*W-1:0]      ptDelay;
  logic [N-1:0]        ptEnable, ptSelect, flagClear, errClear;
  logic                convBusy;
  logic [N-1:0]        preTrig, fireFlags, errFlags;

  assign ptDelay = dly;

  pt_channel dut_i (
    .clk(clk), .rstN(rstN), .trigStrobe(trigStrobe), .cntVal(cntVal),
    .ptDelay(ptDelay), .ptEnable(ptEnable), .ptSelect(ptSelect),
    .convBusy(convBusy), .flagClear(flagClear), .errClear(errClear),
    .preTrig(preTrig), .fireFlags(fireFlags), .errFlags(errFlags)
  );

  always #2.5 clk = ~clk;

  int nVec = 0;
  int nBad = 0;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(logic t, logic [W-1:0] c, logic b, logic [N-1:0] fc, logic [N-1:0] ec);
    @(posedge clk);
    #1;
    trigStrobe = t; cntVal = c; convBusy = b; flagClear = fc; errClear = ec;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [N-1:0] en, sel, expS, ef, ee, col;
    int modv, bLo, bLen;
    logic busy, lowerSeen;
    rstN = 1'b0; trigStrobe = 0; cntVal = '1; convBusy = 0;
    flagClear = '0; errClear = '0; ptEnable = '0; ptSelect = '0; dly = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 preTrig in reset", preTrig, '0);
    chk("R1 fireFlags in reset", fireFlags, '0);
    chk("R1 errFlags in reset", errFlags, '0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 preTrig after reset", preTrig, '0);
    chk("R1 errFlags after reset", errFlags, '0);

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R10 checked every cycle of every run.
    for (int s = 0; s < 48; s++) begin
      en   = N'((s * 37) ^ 8'hA5);
      sel  = N'(s * 53 + 17);
      modv = 10 + s % 12;
      bLo  = s % 9;
      bLen = s % 5;
      @(posedge clk); #1;
      ptEnable = en; ptSelect = sel;
      for (int m = 0; m < N; m++) dly[m] = W'((s * 7 + m * 5) % 24);
      trigStrobe = 0; cntVal = '1; convBusy = 0; flagClear = '1; errClear = '1;
      @(negedge clk);
      ef = '0; ee = '0;
      for (int k = 0; k <= RUNLEN; k++) begin
        busy = (k >= bLo) && (k < bLo + bLen);
        drive(k == 0, (k == 0) ? '1 : W'((k - 1) % (modv + 1)), busy, '0, '0);
        for (int m = 0; m < N; m++) begin
          if (!en[m])      expS[m] = 1'b0;
          else if (sel[m]) expS[m] = (int'(dly[m]) <= modv) && (k == int'(dly[m]) + 2);
          else             expS[m] = (k == 1);
        end
        chk("R2 R3 R4 R5 R10 strobe", preTrig, expS);
        chk("R6 fired flags", fireFlags, ef);
        chk("R7 R8 error flags", errFlags, ee);
        lowerSeen = 1'b0;
        for (int m = 0; m < N; m++) begin
          col[m] = expS[m] && (busy || lowerSeen);
          lowerSeen = lowerSeen || expS[m];
        end
        ef = ef | expS;
        ee = ee | col;
      end
    end

    // R9: set wins over a same-cycle clear, then a clear affects only its own bit.
    @(posedge clk); #1;
    ptEnable = 8'b0000_0011; ptSelect = '0;
    trigStrobe = 0; cntVal = '1; convBusy = 0; flagClear = '1; errClear = '1;
    @(negedge clk);
    drive(1'b1, '1, 1'b0, '0, '0);
    drive(1'b0, '1, 1'b1, 8'b01, 8'b01);
    chk("R9 strobes present", preTrig, 8'b11);
    drive(1'b0, '1, 1'b0, 8'b10, 8'b10);
    chk("R9 set over clear flags", fireFlags, 8'b11);
    chk("R9 set over clear errors", errFlags, 8'b11);
    drive(1'b0, '1, 1'b0, '0, '0);
    chk("R9 per-bit clear flags", fireFlags, 8'b01);
    chk("R9 per-bit clear errors", errFlags, 8'b01);

    // R5: disabling a delayed pre-trigger during its run suppresses the strobe.
    @(posedge clk); #1;
    ptEnable = 8'b1; ptSelect = 8'b1; dly[0] = W'(3);
    flagClear = '1; errClear = '1; cntVal = '1;
    @(negedge clk);
    for (int k = 0; k <= 8; k++) begin
      drive(k == 0, (k == 0) ? '1 : W'(k - 1), 1'b0, '0, '0);
      if (k == 1) ptEnable = '0;
      if (k == 6) ptEnable = 8'b1;
      chk("R5 disabled mid-run", preTrig, '0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule